// File: doc/BRIEF.md
# Path Overhead Byte Monitor

This block watches three overhead bytes of a received SONET/SDH path on each of three ports, once per frame. It does not frame or extract the bytes itself. An upstream extractor presents each byte with a one-cycle strobe.

The N1 and K3 bytes pass through a persistence filter. A new value is latched as the monitor value only after the same byte has arrived in enough consecutive frames. The C2 signal label is checked on every arrival for two conditions: the unequipped code, and a difference from a programmed expected label.

Each change of a latched value and each C2 condition sets a sticky status bit. A mask bit per status bit decides whether it drives the single interrupt line. Software reads and clears the status bits through a small register port, either by reading them or by writing ones. In the single high-order modes only port 0 carries status, and the other ports present zeros.

Top module: `pohByteMonitor`

## Requirements
- R1: The N1 monitor value of a port takes a new byte only once that byte has arrived on the port's N1 strobe in at least `cntN1` consecutive strobes. A different byte restarts the run at 1, with that byte as the candidate.
- R2: The K3 monitor value follows the rule of R1, using its own count `cntK3`.
- R3: A count setting of 0 behaves as 1, so any new byte is accepted on its first arrival.
- R4: Status bit 4p+0 (N1 change) or 4p+1 (K3 change) is set in the cycle after the latched value of port p changes. Re-accepting an equal value sets nothing.
- R5: Status bit 4p+2 is set in the cycle after a C2 strobe on port p carries 0x00.
- R6: Status bit 4p+3 is set in the cycle after a C2 strobe on port p carries a byte different from `c2Exp[p]`.
- R7: `irq` is high exactly when some visible status bit is set and its mask bit (same position) is 0.
- R8: With `corMode`=1, a read of register 0 returns the status and then clears every status bit. Writes to register 0 have no effect.
- R9: With `corMode`=0, writing register 0 clears the status bits written as 1. Reads of register 0 do not clear anything.
- R10: When a status bit is set and cleared in the same cycle, it ends up set.
- R11: With `hoMode`=1, ports 1 and 2 report zero monitor values and zero status, and they can neither set status nor raise `irq`.
- R12: After reset, all monitor values and status bits are 0 and all mask bits are 1.
- R13: `regRdata` holds, in the cycle after `regRd`, the register at `regAddr`:
  - 0: status (bits 11:0)
  - 1: mask (bits 11:0)
  - 2: N1 monitors, with port p at bits 8p+7:8p
  - 3: K3 monitors, with the same byte layout as register 2

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hoMode | input | 1 | Single high-order mode: only port 0 is valid |
| corMode | input | 1 | 1: clear status on read; 0: clear on write of 1 |
| cntN1 | input | 4 | N1 persistence count |
| cntK3 | input | 4 | K3 persistence count |
| c2Exp | input | 3x8 | Expected C2 label per port |
| c2Strb | input | 3 | C2 byte strobe per port |
| c2Byte | input | 3x8 | Received C2 byte per port |
| n1Strb | input | 3 | N1 byte strobe per port |
| n1Byte | input | 3x8 | Received N1 byte per port |
| k3Strb | input | 3 | K3 byte strobe per port |
| k3Byte | input | 3x8 | Received K3 byte per port |
| regAddr | input | 2 | Register select |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 24 | Register write data |
| regRdata | output | 24 | Register read data, one cycle after `regRd` |
| n1Mon | output | 3x8 | Latched N1 value per port |
| k3Mon | output | 3x8 | Latched K3 value per port |
| statusBits | output | 12 | Visible sticky status bits |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a run that hits the persistence threshold at every possible count, including count 0. The bench sweeps the count settings and feeds run lengths that step around each threshold. It interleaves ports so that each port's candidate tracking is exercised on its own.

Collisions between a clear and a new event in the same cycle are also hard to reach. They arise naturally in that sweep, because status reads and clearing writes land on frames that set bits. One directed step also forces an unequipped label onto the same cycle as a clearing read.

// File: rtl/pohPkg.sv
package pohPkg;
  localparam int EVT_W = 4;

  // Per-port strobes from datapath to control; n1Chg is bit 0.
  typedef struct packed {
    logic plm;
    logic uneq;
    logic k3Chg;
    logic n1Chg;
  } pohEvt_t;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1,
    REG_N1   = 2'd2,
    REG_K3   = 2'd3
  } pohReg_e;
endpackage

// File: rtl/pohPersistFilter.sv
module pohPersistFilter #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strb,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [CNT_W-1:0]  thrCfg,
  output logic [BYTE_W-1:0] monVal,
  output logic              chg
);
  logic [BYTE_W-1:0] cand;
  logic [CNT_W-1:0]  runCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic [CNT_W-1:0]  thr;

  always_comb begin
    thr = (thrCfg == '0) ? CNT_W'(1) : thrCfg;
    if (inByte == cand) begin
      nextCnt = (runCnt == '1) ? runCnt : runCnt + CNT_W'(1);
    end else begin
      nextCnt = CNT_W'(1);
    end
    chg = strb && (nextCnt >= thr) && (inByte != monVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cand   <= '0;
      runCnt <= '0;
      monVal <= '0;
    end else if (strb) begin
      cand   <= inByte;
      runCnt <= nextCnt;
      if (chg) monVal <= inByte;
    end
  end
endmodule

// File: rtl/pohDatapath.sv
module pohDatapath
  import pohPkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [CNT_W-1:0]                  cntN1,
  input  logic [CNT_W-1:0]                  cntK3,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  c2Exp,
  input  logic [NUM_PORTS-1:0]              c2Strb,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  c2Byte,
  input  logic [NUM_PORTS-1:0]              n1Strb,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  n1Byte,
  input  logic [NUM_PORTS-1:0]              k3Strb,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  k3Byte,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  n1Mon,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  k3Mon,
  output pohEvt_t [NUM_PORTS-1:0]           evt
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic n1Chg;
    logic k3Chg;

    pohPersistFilter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_n1Filt (
      .clk(clk), .rstN(rstN), .strb(n1Strb[p]), .inByte(n1Byte[p]),
      .thrCfg(cntN1), .monVal(n1Mon[p]), .chg(n1Chg)
    );

    pohPersistFilter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_k3Filt (
      .clk(clk), .rstN(rstN), .strb(k3Strb[p]), .inByte(k3Byte[p]),
      .thrCfg(cntK3), .monVal(k3Mon[p]), .chg(k3Chg)
    );

    always_comb begin
      evt[p].n1Chg = n1Chg;
      evt[p].k3Chg = k3Chg;
      evt[p].uneq  = c2Strb[p] && (c2Byte[p] == '0);
      evt[p].plm   = c2Strb[p] && (c2Byte[p] != c2Exp[p]);
    end
  end
endmodule

// File: rtl/pohIntCtrl.sv
module pohIntCtrl
  import pohPkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int BYTE_W    = 8,
  localparam int DATA_W   = NUM_PORTS * BYTE_W,
  localparam int ST_W     = NUM_PORTS * EVT_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  pohEvt_t [NUM_PORTS-1:0]           evt,
  input  logic                              hoMode,
  input  logic                              corMode,
  input  logic [1:0]                        regAddr,
  input  logic                              regRd,
  input  logic                              regWr,
  input  logic [DATA_W-1:0]                 regWdata,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  n1Raw,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  k3Raw,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  n1Vis,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  k3Vis,
  output logic [ST_W-1:0]                   statusVis,
  output logic                              irq,
  output logic [DATA_W-1:0]                 regRdata
);
  logic [ST_W-1:0]      status;
  logic [ST_W-1:0]      maskReg;
  logic [ST_W-1:0]      setVec;
  logic [ST_W-1:0]      clrVec;
  logic [ST_W-1:0]      visMask;
  logic [NUM_PORTS-1:0] portOn;
  logic                 statSel;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_vis
    assign portOn[p] = (p == 0) || !hoMode;
    assign visMask[p*EVT_W +: EVT_W] = {EVT_W{portOn[p]}};
    assign setVec[p*EVT_W +: EVT_W]  = portOn[p] ? evt[p] : '0;
    assign n1Vis[p] = portOn[p] ? n1Raw[p] : '0;
    assign k3Vis[p] = portOn[p] ? k3Raw[p] : '0;
  end

  assign statSel = (regAddr == REG_STAT);

  always_comb begin
    clrVec = '0;
    if (regRd && statSel && corMode) clrVec = '1;
    if (regWr && statSel && !corMode) clrVec = regWdata[ST_W-1:0];
  end

  assign statusVis = status & visMask;
  assign irq = |(statusVis & ~maskReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status   <= '0;
      maskReg  <= '1;
      regRdata <= '0;
    end else begin
      status <= (status & ~clrVec) | setVec;
      if (regWr && (regAddr == REG_MASK)) maskReg <= regWdata[ST_W-1:0];
      if (regRd) begin
        unique case (regAddr)
          REG_STAT: regRdata <= {{(DATA_W-ST_W){1'b0}}, statusVis};
          REG_MASK: regRdata <= {{(DATA_W-ST_W){1'b0}}, maskReg};
          REG_N1:   regRdata <= n1Vis;
          default:  regRdata <= k3Vis;
        endcase
      end
    end
  end
endmodule

// File: rtl/pohByteMonitor.sv
module pohByteMonitor
  import pohPkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 4,
  localparam int DATA_W   = NUM_PORTS * BYTE_W,
  localparam int ST_W     = NUM_PORTS * EVT_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              hoMode,
  input  logic                              corMode,
  input  logic [CNT_W-1:0]                  cntN1,
  input  logic [CNT_W-1:0]                  cntK3,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  c2Exp,
  input  logic [NUM_PORTS-1:0]              c2Strb,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  c2Byte,
  input  logic [NUM_PORTS-1:0]              n1Strb,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  n1Byte,
  input  logic [NUM_PORTS-1:0]              k3Strb,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  k3Byte,
  input  logic [1:0]                        regAddr,
  input  logic                              regRd,
  input  logic                              regWr,
  input  logic [DATA_W-1:0]                 regWdata,
  output logic [DATA_W-1:0]                 regRdata,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  n1Mon,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  k3Mon,
  output logic [ST_W-1:0]                   statusBits,
  output logic                              irq
);
  pohEvt_t [NUM_PORTS-1:0]          evt;
  logic [NUM_PORTS-1:0][BYTE_W-1:0] n1Raw;
  logic [NUM_PORTS-1:0][BYTE_W-1:0] k3Raw;

  pohDatapath #(.NUM_PORTS(NUM_PORTS), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cntN1(cntN1), .cntK3(cntK3), .c2Exp(c2Exp),
    .c2Strb(c2Strb), .c2Byte(c2Byte), .n1Strb(n1Strb), .n1Byte(n1Byte),
    .k3Strb(k3Strb), .k3Byte(k3Byte), .n1Mon(n1Raw), .k3Mon(k3Raw), .evt(evt)
  );

  pohIntCtrl #(.NUM_PORTS(NUM_PORTS), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .hoMode(hoMode), .corMode(corMode),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .n1Raw(n1Raw), .k3Raw(k3Raw), .n1Vis(n1Mon), .k3Vis(k3Mon),
    .statusVis(statusBits), .irq(irq), .regRdata(regRdata)
  );
endmodule

// File: rtl/pohByteMonitorChk.sv
module pohByteMonitorChk #(
  parameter int NUM_PORTS = 3,
  parameter int BYTE_W    = 8,
  localparam int ST_W     = NUM_PORTS * 4
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              hoMode,
  input logic [NUM_PORTS-1:0][BYTE_W-1:0]  c2Exp,
  input logic [NUM_PORTS-1:0]              c2Strb,
  input logic [NUM_PORTS-1:0][BYTE_W-1:0]  c2Byte,
  input logic [NUM_PORTS-1:0]              n1Strb,
  input logic [NUM_PORTS-1:0]              k3Strb,
  input logic [NUM_PORTS-1:0][BYTE_W-1:0]  n1Mon,
  input logic [NUM_PORTS-1:0][BYTE_W-1:0]  k3Mon,
  input logic [ST_W-1:0]                   statusBits,
  input logic                              irq
);
  // R1
  n1_change_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(n1Mon[0]) |-> $past(n1Strb[0]));

  // R2
  k3_change_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(k3Mon[0]) |-> $past(k3Strb[0]));

  // R4
  n1_delta_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(n1Mon[0]) |-> statusBits[0]);

  // R4
  k3_delta_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(k3Mon[0]) |-> statusBits[1]);

  // R5
  uneq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (c2Strb[0] && (c2Byte[0] == '0)) |=> statusBits[2]);

  // R6
  plm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (c2Strb[0] && (c2Byte[0] != c2Exp[0])) |=> statusBits[3]);

  // R7
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|statusBits));

  // R11
  ho_hidden_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    hoMode |-> ((statusBits[ST_W-1:4] == '0) && (n1Mon[NUM_PORTS-1:1] == '0)
                && (k3Mon[NUM_PORTS-1:1] == '0)));
endmodule

bind pohByteMonitor pohByteMonitorChk #(.NUM_PORTS(NUM_PORTS), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .hoMode(hoMode), .c2Exp(c2Exp), .c2Strb(c2Strb),
  .c2Byte(c2Byte), .n1Strb(n1Strb), .k3Strb(k3Strb), .n1Mon(n1Mon),
  .k3Mon(k3Mon), .statusBits(statusBits), .irq(irq)
);

// File: tb/pohByteMonitor_tb.sv
`timescale 1ns/1ps
module pohByteMonitor_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hoMode = 1'b0;
  logic corMode = 1'b0;
  logic [3:0] cntN1 = '0;
  logic [3:0] cntK3 = '0;
  logic [2:0][7:0] c2Exp;
  logic [2:0] c2Strb = '0;
  logic [2:0][7:0] c2Byte = '0;
  logic [2:0] n1Strb = '0;
  logic [2:0][7:0] n1Byte = '0;
  logic [2:0] k3Strb = '0;
  logic [2:0][7:0] k3Byte = '0;
  logic [1:0] regAddr = '0;
  logic regRd = 1'b0;
  logic regWr = 1'b0;
  logic [23:0] regWdata = '0;
  logic [23:0] regRdata;
  logic [2:0][7:0] n1Mon;
  logic [2:0][7:0] k3Mon;
  logic [11:0] statusBits;
  logic irq;

  int tests = 0;
  int fails = 0;

  // reference state, built from the requirements
  logic [7:0] mCand [2][3];
  int         mCnt  [2][3];
  logic [7:0] mMon  [2][3];
  logic [11:0] mStat;
  logic [11:0] mMask;

  always #4 clk = ~clk;

  pohByteMonitor u_dut (
    .clk(clk), .rstN(rstN), .hoMode(hoMode), .corMode(corMode), .cntN1(cntN1),
    .cntK3(cntK3), .c2Exp(c2Exp), .c2Strb(c2Strb), .c2Byte(c2Byte),
    .n1Strb(n1Strb), .n1Byte(n1Byte), .k3Strb(k3Strb), .k3Byte(k3Byte),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .n1Mon(n1Mon), .k3Mon(k3Mon),
    .statusBits(statusBits), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit portOn(input int p);
    return (p == 0) || !hoMode;
  endfunction

  function automatic logic [11:0] visOf();
    return hoMode ? 12'h00F : 12'hFFF;
  endfunction

  function automatic logic [23:0] monWord(input int k);
    logic [23:0] w = '0;
    for (int p = 0; p < 3; p++) if (portOn(p)) w[p*8 +: 8] = mMon[k][p];
    return w;
  endfunction

  function automatic logic [23:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return {12'h0, mStat & visOf()};
      2'd1: return {12'h0, mMask};
      2'd2: return monWord(0);
      default: return monWord(1);
    endcase
  endfunction

  task automatic mFilt(input int k, input int p, input logic [7:0] b, input int thrCfg, output bit c);
    int t;
    if (b == mCand[k][p]) mCnt[k][p] = (mCnt[k][p] >= 15) ? 15 : mCnt[k][p] + 1;
    else begin
      mCand[k][p] = b;
      mCnt[k][p] = 1;
    end
    t = (thrCfg == 0) ? 1 : thrCfg;
    c = (mCnt[k][p] >= t) && (b != mMon[k][p]);
    if (c) mMon[k][p] = b;
  endtask

  task automatic checkOuts(input string tag);
    logic [23:0] e;
    e = monWord(0);
    chk(n1Mon == e, (cntN1 == 0) ? {tag, " R3 R1 n1Mon"} : {tag, " R1 n1Mon"}, n1Mon, e);
    e = monWord(1);
    chk(k3Mon == e, (cntK3 == 0) ? {tag, " R3 R2 k3Mon"} : {tag, " R2 k3Mon"}, k3Mon, e);
    chk(statusBits == (mStat & visOf()), {tag, " R4/R5/R6/R8/R9 status"},
        {12'h0, statusBits}, {12'h0, mStat & visOf()});
    chk(irq == (|(mStat & visOf() & ~mMask)), {tag, " R7 irq"}, {23'h0, irq},
        {23'h0, |(mStat & visOf() & ~mMask)});
  endtask

  task automatic step(input int p, input bit fr, input logic [7:0] n1, input logic [7:0] k3,
                      input logic [7:0] c2, input bit rd, input bit wr, input logic [1:0] a,
                      input logic [23:0] wd, input string tag);
    logic [23:0] rdExp;
    logic [11:0] clr;
    logic [11:0] setv;
    bit c;
    @(negedge clk);
    rdExp = modelRead(a);
    if (fr) begin
      n1Strb[p] = 1'b1; n1Byte[p] = n1;
      k3Strb[p] = 1'b1; k3Byte[p] = k3;
      c2Strb[p] = 1'b1; c2Byte[p] = c2;
    end
    regRd = rd; regWr = wr; regAddr = a; regWdata = wd;
    clr = '0;
    if (rd && a == 2'd0 && corMode) clr = '1;
    if (wr && a == 2'd0 && !corMode) clr = wd[11:0];
    if (wr && a == 2'd1) mMask = wd[11:0];
    setv = '0;
    if (fr) begin
      mFilt(0, p, n1, int'(cntN1), c);
      if (c && portOn(p)) setv[p*4+0] = 1'b1;
      mFilt(1, p, k3, int'(cntK3), c);
      if (c && portOn(p)) setv[p*4+1] = 1'b1;
      if (portOn(p) && c2 == 8'h00) setv[p*4+2] = 1'b1;
      if (portOn(p) && c2 != c2Exp[p]) setv[p*4+3] = 1'b1;
    end
    mStat = (mStat & ~clr) | setv;
    @(negedge clk);
    n1Strb = '0; k3Strb = '0; c2Strb = '0;
    regRd = 1'b0; regWr = 1'b0;
    checkOuts(tag);
    if (rd) chk(regRdata == rdExp, {tag, " R13 regRdata"}, regRdata, rdExp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    c2Exp = {8'h24, 8'h13, 8'h02};
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < 3; p++) begin
        mCand[k][p] = 8'h00; mCnt[k][p] = 0; mMon[k][p] = 8'h00;
      end
    mStat = '0;
    mMask = 12'hFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOuts("R12 reset");
    step(0, 0, 0, 0, 0, 1, 0, 2'd1, 0, "R12 mask reset");

    // sweep: clear mode x count settings x interleaved runs on all ports
    for (int cor = 0; cor < 2; cor++) begin
      for (int thr = 0; thr < 6; thr++) begin
        corMode = cor[0];
        cntN1 = 4'(thr);
        cntK3 = 4'(5 - thr);
        for (int i = 0; i < 36; i++) begin
          int p = i % 3;
          int r = i / 3;
          logic [7:0] n1v = ((r % (thr + 2)) <= thr) ? 8'h3C + 8'(p) : 8'hC3;
          logic [7:0] k3v = ((r % 3) == 0) ? 8'h11 : 8'h22;
          logic [7:0] c2v = ((r % 4) == 0) ? 8'h00 :
                            ((r % 4) == 1) ? c2Exp[p] : 8'h40 + 8'(r);
          if (i % 5 == 4)
            step(p, 1, n1v, k3v, c2v, cor[0], !cor[0], 2'd0, 24'h0005A5,
                 cor[0] ? "R8 R10 sweep" : "R9 R10 sweep");
          else if (i % 7 == 6)
            step(p, 1, n1v, k3v, c2v, 1, 0, 2'(2 + (i % 2)), 0, "R13 sweep");
          else
            step(p, 1, n1v, k3v, c2v, 0, 0, 2'd0, 0, "R1 R2 sweep");
        end
      end
    end

    // R9: reads do not clear in write mode; R8: writes ignored in read mode
    corMode = 1'b0;
    step(0, 1, 8'h3C, 8'h11, 8'h00, 0, 0, 0, 0, "R5 set");
    step(0, 0, 0, 0, 0, 1, 0, 2'd0, 0, "R9 read keeps");
    step(0, 0, 0, 0, 0, 0, 1, 2'd0, 24'hFFF, "R9 write clears");
    corMode = 1'b1;
    step(0, 1, 8'h3C, 8'h11, 8'h00, 0, 0, 0, 0, "R5 set");
    step(0, 0, 0, 0, 0, 0, 1, 2'd0, 24'hFFF, "R8 write ignored");
    // R10: clearing read and unequipped label land in the same cycle
    step(0, 1, 8'h3C, 8'h11, 8'h00, 1, 0, 2'd0, 0, "R10 set wins");
    chk(statusBits[2] == 1'b1, "R10 uneq kept", {23'h0, statusBits[2]}, 24'h1);

    // R7: mask sweep over port 0 bits
    step(0, 1, 8'h3C, 8'h11, 8'h00, 0, 0, 0, 0, "R6 set");
    for (int m = 0; m < 16; m++)
      step(0, 0, 0, 0, 0, 0, 1, 2'd1, 24'(12'hFF0 | m), "R7 mask sweep");

    // R11: single high-order mode hides ports 1 and 2
    hoMode = 1'b1;
    step(0, 0, 0, 0, 0, 0, 1, 2'd1, 24'h000, "R11 unmask");
    for (int i = 0; i < 12; i++) begin
      int p = i % 3;
      step(p, 1, 8'h70 + 8'(i / 3), 8'h90, 8'h00, (i % 4 == 3), 0, 2'(i % 4), 0, "R11 ho");
    end
    hoMode = 1'b0;
    step(1, 0, 0, 0, 0, 1, 0, 2'd2, 0, "R11 ho exit");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule